// File: doc/BRIEF.md
# Write Buffer with Read Bypass and Selectable Ordering

This block sits between one in-order core and a shared memory port. The core presents requests (read or write, address, write data) with a valid/ready handshake. Writes are parked in a small buffer and drained to memory one at a time, oldest first. In the relaxed mode a read that misses the buffer goes to memory ahead of the writes still waiting. A read that hits the buffer is answered at once with the youngest matching buffered data, and memory never sees it.

A mode input selects strict ordering. In that mode every access runs to completion before the next is taken, so a read never passes a write. A drain input stops new requests and blocks bypassing until every buffered write has been acknowledged. A drained output reports an empty buffer. The memory side has one request in flight at a time. It holds the request until a single-cycle acknowledge, which also carries read data.

Top module: `wbuf_bypass`

## Requirements
- R1: Writes reach the memory port in the same order the core handed them over.
- R2: In relaxed mode, a read that misses the buffer is sent to memory before older buffered writes that have not yet been sent. Once a read miss is accepted, req_ready stays low until its data has been returned.
- R3: A read whose address matches a buffered write (including the one in flight) returns the data of the youngest such write. rsp_valid is high in the first cycle after acceptance, and no memory read is made.
- R4: The buffer holds DEPTH (4) writes, counting the one in flight. While it is full, req_ready is low for every request type.
- R5: At most one memory request is outstanding. mem_valid, mem_is_wr and mem_addr hold steady until the cycle mem_ack is high, and mem_valid is low in the cycle after.
- R6: With strict_mode high, req_ready is high only when the buffer is empty, no memory request is outstanding and no read is pending. Accesses therefore reach memory in program order, with no bypass.
- R7: While drain_req is high, req_ready is low and a pending read miss is held back until the buffer is empty. Buffered writes keep draining.
- R8: drained is high exactly when the buffer holds no write, including any write in flight.
- R9: After reset: req_ready high, mem_valid low, rsp_valid low, drained high.
- R10: Read-miss data is the mem_rdata value sampled in the mem_ack cycle. It is returned on rsp_rdata with a one-cycle rsp_valid pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strict_mode | input | 1 | 1 = fully serialised ordering, 0 = reads may bypass writes |
| drain_req | input | 1 | Block new requests and bypass, empty the buffer |
| drained | output | 1 | No writes remain in the buffer |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Block can take a request |
| req_is_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DW | Read data to the core |
| mem_valid | output | 1 | Memory request outstanding |
| mem_is_wr | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completion pulse |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |

## Verification
A corrupted buffer pointer or fill count shows up at the memory port. Write addresses or data come out in the wrong order or are duplicated, on the next drain, within a few memory round trips, and drained either rises while writes remain or never rises. A wrong forwarding choice shows as stale data on rsp_rdata one cycle after the read is accepted. A broken issue priority is visible in the order of operations the memory sees: a read that should bypass lands after a queued write, or, under strict or drain, a read passes a write. The bench records every completed memory operation and compares that log and the returned data against program-order expectations.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
  // Kind of request currently held on the memory port
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;
endpackage

// File: rtl/wbuf_fifo.sv
`timescale 1ns/1ps
// Program-ordered write storage. The head entry stays until its write is
// acknowledged, so it can still be forwarded while in flight.
module wbuf_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] age_addr [DEPTH],
  output logic [DW-1:0] age_data [DEPTH],
  output logic [DEPTH-1:0] age_live
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] a_mem [DEPTH];
  logic [DW-1:0] d_mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] fill, fill_nxt;

  always_ff @(posedge clk) begin
    if (push) begin
      a_mem[wr_ptr] <= push_addr;
      d_mem[wr_ptr] <= push_data;
    end
  end

  always_comb begin
    fill_nxt = fill;
    if (push && !pop) fill_nxt = fill + 1'b1;
    else if (pop && !push) fill_nxt = fill - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      fill  <= fill_nxt;
      full  <= (fill_nxt == CW'(DEPTH));
      empty <= (fill_nxt == '0);
    end
  end

  assign head_addr = a_mem[rd_ptr];
  assign head_data = d_mem[rd_ptr];

  // Entries presented oldest first (index 0 = head)
  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    logic [PW-1:0] slot;
    assign slot        = rd_ptr + PW'(g);
    assign age_addr[g] = a_mem[slot];
    assign age_data[g] = d_mem[slot];
    assign age_live[g] = (CW'(g) < fill);
  end
endmodule

// File: rtl/wbuf_fwd.sv
`timescale 1ns/1ps
// Address match across the buffered writes; the youngest match wins.
module wbuf_fwd #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic [AW-1:0]    look_addr,
  input  logic [AW-1:0]    age_addr [DEPTH],
  input  logic [DW-1:0]    age_data [DEPTH],
  input  logic [DEPTH-1:0] age_live,
  output logic             hit,
  output logic [DW-1:0]    hit_data
);
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (age_live[i] && (age_addr[i] == look_addr)) begin
        hit      = 1'b1;
        hit_data = age_data[i];
      end
    end
  end
endmodule

// File: rtl/wbuf_issue.sv
`timescale 1ns/1ps
// Single-outstanding memory port. A ready read has priority over the head write.
module wbuf_issue import wbuf_pkg::*; #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_avail,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_ack,
  output logic          mem_valid,
  output logic          mem_is_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          wr_done,
  output logic          rd_done
);
  op_e kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      kind      <= OP_READ;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (mem_valid) begin
      if (mem_ack) mem_valid <= 1'b0;
    end else if (rd_go) begin
      mem_valid <= 1'b1;
      kind      <= OP_READ;
      mem_addr  <= rd_addr;
    end else if (wr_avail) begin
      mem_valid <= 1'b1;
      kind      <= OP_WRITE;
      mem_addr  <= head_addr;
      mem_wdata <= head_data;
    end
  end

  assign mem_is_wr = (kind == OP_WRITE);
  assign wr_done   = mem_valid && mem_ack && (kind == OP_WRITE);
  assign rd_done   = mem_valid && mem_ack && (kind == OP_READ);
endmodule

// File: rtl/wbuf_bypass.sv
`timescale 1ns/1ps
module wbuf_bypass #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strict_mode,
  input  logic          drain_req,
  output logic          drained,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_is_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_valid,
  output logic          mem_is_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  logic [AW-1:0]    head_addr;
  logic [DW-1:0]    head_data;
  logic             buf_full, buf_empty;
  logic [AW-1:0]    age_addr [DEPTH];
  logic [DW-1:0]    age_data [DEPTH];
  logic [DEPTH-1:0] age_live;
  logic             fwd_hit;
  logic [DW-1:0]    fwd_data;
  logic             wr_done, rd_done;
  logic             rd_pend;
  logic [AW-1:0]    rd_addr_q;
  logic             accept, wr_acc, rd_acc, rd_go;

  // Ready depends only on state and mode inputs, never on the request itself
  assign req_ready = !rd_pend && !drain_req &&
                     (strict_mode ? (buf_empty && !mem_valid) : !buf_full);
  assign accept = req_valid && req_ready;
  assign wr_acc = accept && req_is_wr;
  assign rd_acc = accept && !req_is_wr;
  // A pending miss may bypass only in relaxed mode with no drain request
  assign rd_go  = rd_pend && (buf_empty || (!strict_mode && !drain_req));

  wbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst),
    .push(wr_acc), .push_addr(req_addr), .push_data(req_wdata),
    .pop(wr_done),
    .head_addr(head_addr), .head_data(head_data),
    .full(buf_full), .empty(buf_empty),
    .age_addr(age_addr), .age_data(age_data), .age_live(age_live)
  );

  wbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .look_addr(req_addr),
    .age_addr(age_addr), .age_data(age_data), .age_live(age_live),
    .hit(fwd_hit), .hit_data(fwd_data)
  );

  wbuf_issue #(.AW(AW), .DW(DW)) u_issue (
    .clk(clk), .rst(rst),
    .rd_go(rd_go), .rd_addr(rd_addr_q),
    .wr_avail(!buf_empty),
    .head_addr(head_addr), .head_data(head_data),
    .mem_ack(mem_ack),
    .mem_valid(mem_valid), .mem_is_wr(mem_is_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wr_done(wr_done), .rd_done(rd_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend   <= 1'b0;
      rd_addr_q <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (rd_acc && fwd_hit) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= fwd_data;
      end else if (rd_acc) begin
        rd_pend   <= 1'b1;
        rd_addr_q <= req_addr;
      end
      if (rd_done) begin
        rd_pend   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_rdata <= mem_rdata;
      end
    end
  end

  assign drained = buf_empty;
endmodule

// File: rtl/wbuf_bypass_chk.sv
`timescale 1ns/1ps
module wbuf_bypass_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          strict_mode,
  input logic          drain_req,
  input logic          drained,
  input logic          req_ready,
  input logic          mem_valid,
  input logic          mem_is_wr,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ack |=> mem_valid && $stable(mem_addr) && $stable(mem_is_wr)
      && (!mem_is_wr || $stable(mem_wdata)));

  // R5
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ack |=> !mem_valid);

  // R8
  drained_inflight_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_is_wr |-> !drained);

  // R6
  strict_serial_chk: assert property (@(posedge clk) disable iff (rst)
    strict_mode && mem_valid |-> !req_ready);

  // R7
  drain_block_chk: assert property (@(posedge clk) disable iff (rst)
    drain_req |-> !req_ready);
endmodule

bind wbuf_bypass wbuf_bypass_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .strict_mode(strict_mode), .drain_req(drain_req),
  .drained(drained), .req_ready(req_ready), .mem_valid(mem_valid),
  .mem_is_wr(mem_is_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack)
);

// File: tb/test_wbuf_bypass.sv
`timescale 1ns/1ps
module test_wbuf_bypass;
  localparam int AW  = 8;
  localparam int DW  = 16;
  localparam int LAT = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic strict_mode = 1'b0, drain_req = 1'b0, drained;
  logic req_valid = 1'b0, req_ready, req_is_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic mem_valid, mem_is_wr;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #4 clk = ~clk;

  wbuf_bypass #(.DEPTH(4), .AW(AW), .DW(DW)) i_wbuf_bypass (
    .clk(clk), .rst(rst), .strict_mode(strict_mode), .drain_req(drain_req),
    .drained(drained), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_wr(req_is_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_valid(mem_valid),
    .mem_is_wr(mem_is_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // Memory model and log of completed operations
  logic [DW-1:0] shadow [256];
  logic          log_wr [256];
  logic [AW-1:0] log_a  [256];
  logic [DW-1:0] log_d  [256];
  int n_ops = 0;
  bit mem_stall = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    int lat = 0;
    for (int a = 0; a < 256; a++) shadow[a] = {8'h5A, a[7:0]};
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        lat = 0;
      end else if (mem_valid && !mem_stall && !rst) begin
        lat++;
        if (lat >= LAT) begin
          mem_ack = 1'b1;
          log_wr[n_ops] = mem_is_wr;
          log_a[n_ops]  = mem_addr;
          if (mem_is_wr) begin
            shadow[mem_addr] = mem_wdata;
            log_d[n_ops] = mem_wdata;
          end else begin
            mem_rdata = shadow[mem_addr];
            log_d[n_ops] = mem_rdata;
          end
          n_ops++;
        end
      end
    end
  end

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_is_wr = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wait_rsp(output int cyc, output logic [DW-1:0] data);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!rsp_valid && cyc < 200);
    data = rsp_rdata;
  endtask

  task automatic wait_drained();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(drained && !mem_valid) && n < 500);
  endtask

  task automatic chk_op(input int idx, input bit wr, input logic [AW-1:0] a,
                        input string req);
    chk(log_wr[idx] == wr && log_a[idx] == a, req, "memory op order",
        {log_wr[idx], log_a[idx]}, {wr, a});
  endtask

  // {is_wr, addr, wdata, expected read data}
  localparam logic [40:0] VEC [10] = '{
    {1'b1, 8'h10, 16'h1111, 16'h0000},
    {1'b1, 8'h20, 16'h2222, 16'h0000},
    {1'b0, 8'h10, 16'h0000, 16'h1111},
    {1'b0, 8'h30, 16'h0000, 16'h5A30},
    {1'b1, 8'h10, 16'h3333, 16'h0000},
    {1'b0, 8'h10, 16'h0000, 16'h3333},
    {1'b1, 8'h30, 16'h4444, 16'h0000},
    {1'b0, 8'h40, 16'h0000, 16'h5A40},
    {1'b0, 8'h30, 16'h0000, 16'h4444},
    {1'b0, 8'h20, 16'h0000, 16'h2222}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cyc, base, nrd10;
    logic [DW-1:0] d;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(req_ready == 1'b1, "R9", "req_ready", req_ready, 1);
    chk(mem_valid == 1'b0, "R9", "mem_valid", mem_valid, 0);
    chk(rsp_valid == 1'b0, "R9", "rsp_valid", rsp_valid, 0);
    chk(drained == 1'b1, "R9", "drained", drained, 1);

    // Table walk, relaxed mode: R2 R3 R10 data in program order
    for (int i = 0; i < 10; i++) begin
      do_req(VEC[i][40], VEC[i][39:32], VEC[i][31:16]);
      if (!VEC[i][40]) begin
        wait_rsp(cyc, d);
        chk(rsp_valid && d == VEC[i][15:0], "R3/R10", "read data", d, VEC[i][15:0]);
        if (i == 2) chk(cyc == 1, "R3", "hit latency", cyc, 1);
      end
    end
    wait_drained();
    // R1 write order
    base = 0;
    for (int k = 0; k < n_ops; k++) if (log_wr[k]) begin
      case (base)
        0: chk(log_a[k] == 8'h10 && log_d[k] == 16'h1111, "R1", "write 0", log_d[k], 16'h1111);
        1: chk(log_a[k] == 8'h20 && log_d[k] == 16'h2222, "R1", "write 1", log_d[k], 16'h2222);
        2: chk(log_a[k] == 8'h10 && log_d[k] == 16'h3333, "R1", "write 2", log_d[k], 16'h3333);
        3: chk(log_a[k] == 8'h30 && log_d[k] == 16'h4444, "R1", "write 3", log_d[k], 16'h4444);
        default: ;
      endcase
      base++;
    end
    chk(base == 4, "R1", "write count", base, 4);
    nrd10 = 0;
    for (int k = 0; k < n_ops; k++) if (!log_wr[k] && log_a[k] == 8'h10) nrd10++;
    chk(nrd10 == 0, "R3", "memory reads of forwarded address", nrd10, 0);

    // R4 full back-pressure with memory stalled
    mem_stall = 1'b1;
    for (int i = 0; i < 4; i++) do_req(1'b1, AW'(8'h90 + i), DW'(16'h9000 + i));
    @(negedge clk);
    chk(req_ready == 1'b0, "R4", "ready when full", req_ready, 0);
    chk(drained == 1'b0, "R8", "drained with writes buffered", drained, 0);
    mem_stall = 1'b0;
    wait_drained();
    chk(drained == 1'b1, "R8", "drained after empty", drained, 1);

    // R2 bypass: read miss goes ahead of the queued write
    base = n_ops;
    mem_stall = 1'b1;
    do_req(1'b1, 8'hA0, 16'hA0A0);
    do_req(1'b1, 8'hA1, 16'hA1A1);
    do_req(1'b0, 8'hB0, 16'h0000);
    @(negedge clk);
    chk(req_ready == 1'b0, "R2", "ready with read pending", req_ready, 0);
    mem_stall = 1'b0;
    wait_rsp(cyc, d);
    chk(d == 16'h5AB0, "R10", "bypass read data", d, 16'h5AB0);
    wait_drained();
    chk_op(base, 1'b1, 8'hA0, "R2");
    chk_op(base + 1, 1'b0, 8'hB0, "R2");
    chk_op(base + 2, 1'b1, 8'hA1, "R2");

    // R6 strict mode: full serialisation
    base = n_ops;
    strict_mode = 1'b1;
    do_req(1'b1, 8'hC0, 16'hC0C0);
    @(negedge clk);
    chk(req_ready == 1'b0, "R6", "ready while write outstanding", req_ready, 0);
    do_req(1'b1, 8'hC1, 16'hC1C1);
    do_req(1'b0, 8'hC0, 16'h0000);
    wait_rsp(cyc, d);
    chk(d == 16'hC0C0, "R6", "strict read data", d, 16'hC0C0);
    chk_op(base, 1'b1, 8'hC0, "R6");
    chk_op(base + 1, 1'b1, 8'hC1, "R6");
    chk_op(base + 2, 1'b0, 8'hC0, "R6");
    strict_mode = 1'b0;
    wait_drained();

    // R7 drain: requests blocked, pending read held behind writes
    base = n_ops;
    mem_stall = 1'b1;
    do_req(1'b1, 8'hE0, 16'hE0E0);
    do_req(1'b1, 8'hE1, 16'hE1E1);
    do_req(1'b0, 8'hF0, 16'h0000);
    @(negedge clk);
    drain_req = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R7", "ready during drain", req_ready, 0);
    mem_stall = 1'b0;
    wait_rsp(cyc, d);
    chk(d == 16'h5AF0, "R7", "held read data", d, 16'h5AF0);
    chk_op(base, 1'b1, 8'hE0, "R7");
    chk_op(base + 1, 1'b1, 8'hE1, "R7");
    chk_op(base + 2, 1'b0, 8'hF0, "R7");
    wait_drained();
    chk(drained == 1'b1, "R8", "drained after drain", drained, 1);
    drain_req = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7", "ready after drain released", req_ready, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule